// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes characters arriving on the half-duplex I/O line of an ISO 7816 style smart card and hands them to software through four small registers. A sample strobe supplied from outside pulses `OVS` times per elementary time unit (ETU). The block finds the falling start edge and samples each bit at its middle. It checks even parity and keeps four status flags: receive-full, parity error, overrun and wait-time error. From these flags it drives a receive interrupt request and an error interrupt request.

The two protocol modes handle a failed parity check differently. In the character-oriented mode (T=0) the bad character is dropped and the line is pulled low in the guard time so the card repeats it. In the block-oriented mode (T=1) the bad character is still delivered, and it is marked by the parity flag. A wait-time counter, counted in ETUs, flags a card that stays silent for too long. Software either polls the receive-full flag and reads the data register, or it runs from the interrupts.

Top module: `sc_rx_ctrl`

## Requirements
- R1: After reset every register reads 0, both interrupt requests are 0 and the line is not driven. The register map is: address 0 CTRL (bit0 receive enable, bit1 T=1 select, bit2 interrupt enable, bit3 error-interrupts-only), address 1 STAT (bit0 receive-full, bit1 parity error, bit2 overrun, bit3 wait-time error), address 2 DATA, address 3 WAIT (wait limit in ETUs).
- R2: A frame is one low start bit, eight data bits sent LSB first and one even-parity bit. Each bit is sampled OVS/2 strobes after its start. A character with correct parity is loaded into DATA and sets receive-full.
- R3: A read of DATA clears receive-full.
- R4: In T=0 mode a character that fails parity sets the parity flag. DATA and receive-full are left unchanged.
- R5: In T=1 mode a character that fails parity sets the parity flag and is loaded into DATA like a good character.
- R6: In T=0 mode only, a parity failure makes the block drive the line low for NACK_ETUS ETUs, starting half an ETU after the parity sample.
- R7: A character that would be loaded while receive-full is 1 sets the overrun flag, and the old DATA is kept.
- R8: A write to STAT with a 0 in bit 1, 2 or 3 clears that error flag. A 1 in those bits leaves the flag as it is. The error flags change by no other means than such a write.
- R9: With WAIT = N > 0, the wait-time flag is set once N ETUs of strobes have passed with no start bit. Each start bit restarts the count. WAIT = 0 disables the check.
- R10: The receive interrupt is high exactly when interrupt enable is 1, error-interrupts-only is 0 and receive-full is 1.
- R11: The error interrupt is high exactly when interrupt enable is 1 and any error flag is 1.
- R12: While receive enable is 0, line activity is ignored and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_tick | input | 1 | Sample strobe, OVS pulses per ETU |
| io_in | input | 1 | Card I/O line as seen at the pin |
| io_drive_low | output | 1 | Pull the I/O line low (retransmission request) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Receive error interrupt request |

## Verification
The bench builds the block with OVS = 4, NACK_ETUS = 1 and WT_W = 8. With a four-strobe ETU a full frame lasts only forty strobes, so many characters in both modes fit in a short run. It also lets the bench count the exact strobe on which the retransmission pulse rises and falls. An 8-bit WAIT field with small limits places the wait-time expiry within a few frames, both while the line is idle and after a start bit has restarted the count.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_WAIT = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_GAP,
        RX_NACK
    } rx_state_e;

endpackage

// File: rtl/sc_rx_shift.sv
module sc_rx_shift
    import sc_rx_pkg::*;
#(
    parameter int OVS       = 8,
    parameter int NACK_ETUS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       mode_t1,
    input  logic       tick,
    input  logic       line,
    output logic       start_seen,
    output logic       char_done,
    output logic [7:0] char_data,
    output logic       char_par_ok,
    output logic       drive_low
);
    localparam int NACK_TICKS = OVS * NACK_ETUS;
    localparam int CW = $clog2(NACK_TICKS + 1);
    localparam logic [CW-1:0] HALF_END = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] ETU_END  = CW'(OVS - 1);
    localparam logic [CW-1:0] NACK_END = CW'(NACK_TICKS - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] tcnt;
        logic [3:0]    nbit;
        logic [8:0]    sh;
        logic          prev;
        logic          drive;
    } shr_t;

    shr_t q, d;
    logic [8:0] sh_in;

    assign sh_in       = {line, q.sh[8:1]};
    assign char_data   = sh_in[7:0];
    assign char_par_ok = ~^sh_in;
    assign drive_low   = q.drive;

    always_comb begin
        d          = q;
        start_seen = 1'b0;
        char_done  = 1'b0;
        if (tick) begin
            d.prev = line;
        end
        case (q.st)
            RX_IDLE: begin
                if (tick && q.prev && !line) begin
                    d.st       = RX_START;
                    d.tcnt     = '0;
                    start_seen = 1'b1;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.tcnt == HALF_END) begin
                        d.tcnt = '0;
                        d.nbit = '0;
                        d.st   = line ? RX_IDLE : RX_BITS;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            RX_BITS: begin
                if (tick) begin
                    if (q.tcnt == ETU_END) begin
                        d.tcnt = '0;
                        d.sh   = sh_in;
                        d.nbit = q.nbit + 1'b1;
                        if (q.nbit == 4'd8) begin
                            char_done = 1'b1;
                            d.st = (!mode_t1 && !char_par_ok) ? RX_GAP : RX_IDLE;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            RX_GAP: begin
                if (tick) begin
                    if (q.tcnt == HALF_END) begin
                        d.tcnt  = '0;
                        d.drive = 1'b1;
                        d.st    = RX_NACK;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            RX_NACK: begin
                if (tick) begin
                    if (q.tcnt == NACK_END) begin
                        d.tcnt  = '0;
                        d.drive = 1'b0;
                        d.st    = RX_IDLE;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            default: d.st = RX_IDLE;
        endcase
        if (!enable) begin
            d.st       = RX_IDLE;
            d.tcnt     = '0;
            d.drive    = 1'b0;
            start_seen = 1'b0;
            char_done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= RX_IDLE;
            q.tcnt  <= '0;
            q.nbit  <= '0;
            q.sh    <= '0;
            q.prev  <= 1'b1;
            q.drive <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sc_wait_timer.sv
module sc_wait_timer #(
    parameter int OVS  = 8,
    parameter int WT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            tick,
    input  logic            restart,
    input  logic [WT_W-1:0] limit,
    output logic            expire
);
    localparam int SW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [SW-1:0] SUB_END = SW'(OVS - 1);

    typedef struct packed {
        logic [SW-1:0]   sub;
        logic [WT_W-1:0] cnt;
    } wt_t;

    wt_t q, d;

    always_comb begin
        d      = q;
        expire = 1'b0;
        if (!enable || restart || (limit == '0)) begin
            d.sub = '0;
            d.cnt = '0;
        end else if (tick) begin
            if (q.sub == SUB_END) begin
                d.sub = '0;
                if (q.cnt == limit - 1'b1) begin
                    expire = 1'b1;
                    d.cnt  = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sc_rx_regs.sv
module sc_rx_regs
    import sc_rx_pkg::*;
#(
    parameter int WT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [1:0]      reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic            char_done,
    input  logic [7:0]      char_data,
    input  logic            char_par_ok,
    input  logic            wt_expire,
    output logic            ctrl_en,
    output logic            ctrl_t1,
    output logic            ctrl_rie,
    output logic            ctrl_eonly,
    output logic [WT_W-1:0] wt_limit,
    output logic [7:0]      rx_data,
    output logic            flag_full,
    output logic            flag_perr,
    output logic            flag_ovr,
    output logic            flag_wterr,
    output logic            irq_rx,
    output logic            irq_err
);
    typedef struct packed {
        logic            en;
        logic            t1;
        logic            rie;
        logic            eonly;
        logic [WT_W-1:0] wt;
        logic [7:0]      data;
        logic            full;
        logic            perr;
        logic            ovr;
        logic            wterr;
    } regs_t;

    regs_t q, d;
    logic  store;

    always_comb begin
        d     = q;
        store = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_CTRL: begin
                    d.en    = reg_wdata[0];
                    d.t1    = reg_wdata[1];
                    d.rie   = reg_wdata[2];
                    d.eonly = reg_wdata[3];
                end
                ADDR_STAT: begin
                    if (!reg_wdata[1]) d.perr  = 1'b0;
                    if (!reg_wdata[2]) d.ovr   = 1'b0;
                    if (!reg_wdata[3]) d.wterr = 1'b0;
                end
                ADDR_WAIT: d.wt = reg_wdata[WT_W-1:0];
                default: ;
            endcase
        end
        if (reg_rd && (reg_addr == ADDR_DATA)) begin
            d.full = 1'b0;
        end
        if (char_done && q.en) begin
            if (!char_par_ok) begin
                d.perr = 1'b1;
            end
            store = char_par_ok || q.t1;
            if (store) begin
                if (d.full) begin
                    d.ovr = 1'b1;
                end else begin
                    d.data = char_data;
                    d.full = 1'b1;
                end
            end
        end
        if (wt_expire) begin
            d.wterr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {4'b0, q.eonly, q.rie, q.t1, q.en};
            ADDR_STAT: reg_rdata = {4'b0, q.wterr, q.ovr, q.perr, q.full};
            ADDR_DATA: reg_rdata = q.data;
            default:   reg_rdata = 8'(q.wt);
        endcase
    end

    assign ctrl_en    = q.en;
    assign ctrl_t1    = q.t1;
    assign ctrl_rie   = q.rie;
    assign ctrl_eonly = q.eonly;
    assign wt_limit   = q.wt;
    assign rx_data    = q.data;
    assign flag_full  = q.full;
    assign flag_perr  = q.perr;
    assign flag_ovr   = q.ovr;
    assign flag_wterr = q.wterr;
    assign irq_rx     = q.rie && !q.eonly && q.full;
    assign irq_err    = q.rie && (q.perr || q.ovr || q.wterr);

endmodule

// File: rtl/sc_rx_ctrl.sv
module sc_rx_ctrl
    import sc_rx_pkg::*;
#(
    parameter int OVS       = 8,
    parameter int NACK_ETUS = 1,
    parameter int WT_W      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_tick,
    input  logic       io_in,
    output logic       io_drive_low,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_rx,
    output logic       irq_err
);
    logic            ctrl_en, ctrl_t1, ctrl_rie, ctrl_eonly;
    logic [WT_W-1:0] wt_limit;
    logic            start_seen, char_done, char_par_ok, wt_expire;
    logic [7:0]      char_data, rx_data;
    logic            flag_full, flag_perr, flag_ovr, flag_wterr;

    sc_rx_shift #(.OVS(OVS), .NACK_ETUS(NACK_ETUS)) shift_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (ctrl_en),
        .mode_t1     (ctrl_t1),
        .tick        (smp_tick),
        .line        (io_in),
        .start_seen  (start_seen),
        .char_done   (char_done),
        .char_data   (char_data),
        .char_par_ok (char_par_ok),
        .drive_low   (io_drive_low)
    );

    sc_wait_timer #(.OVS(OVS), .WT_W(WT_W)) wtimer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctrl_en),
        .tick    (smp_tick),
        .restart (start_seen),
        .limit   (wt_limit),
        .expire  (wt_expire)
    );

    sc_rx_regs #(.WT_W(WT_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .char_done   (char_done),
        .char_data   (char_data),
        .char_par_ok (char_par_ok),
        .wt_expire   (wt_expire),
        .ctrl_en     (ctrl_en),
        .ctrl_t1     (ctrl_t1),
        .ctrl_rie    (ctrl_rie),
        .ctrl_eonly  (ctrl_eonly),
        .wt_limit    (wt_limit),
        .rx_data     (rx_data),
        .flag_full   (flag_full),
        .flag_perr   (flag_perr),
        .flag_ovr    (flag_ovr),
        .flag_wterr  (flag_wterr),
        .irq_rx      (irq_rx),
        .irq_err     (irq_err)
    );

endmodule

// File: rtl/sc_rx_ctrl_chk.sv
module sc_rx_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       char_done,
    input logic       char_par_ok,
    input logic       ctrl_t1,
    input logic       flag_full,
    input logic       flag_perr,
    input logic       flag_ovr,
    input logic       flag_wterr,
    input logic [7:0] rx_data,
    input logic       io_drive_low,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata
);
    logic rd_data, wr_stat;
    assign rd_data = reg_rd && (reg_addr == 2'd2);
    assign wr_stat = reg_wr && (reg_addr == 2'd1);

    // R3
    a_r3_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !char_done) |=> !flag_full);

    // R4
    a_r4_t0_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !char_par_ok && !ctrl_t1 && !rd_data)
        |=> ($stable(rx_data) && $stable(flag_full) && flag_perr));

    // R5
    a_r5_t1_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !char_par_ok && ctrl_t1 && !flag_full)
        |=> (flag_full && flag_perr));

    // R6 (mode is held constant while a character is in flight)
    a_r6_nack_only_t0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_drive_low) |-> !ctrl_t1);

    // R7
    a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && flag_full && !rd_data && (char_par_ok || ctrl_t1))
        |=> (flag_ovr && $stable(rx_data)));

    // R8
    a_r8_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_perr) |-> $past(wr_stat && !reg_wdata[1]));
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_ovr) |-> $past(wr_stat && !reg_wdata[2]));
    a_r8_wterr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_wterr) |-> $past(wr_stat && !reg_wdata[3]));

endmodule

bind sc_rx_ctrl sc_rx_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .char_done    (char_done),
    .char_par_ok  (char_par_ok),
    .ctrl_t1      (ctrl_t1),
    .flag_full    (flag_full),
    .flag_perr    (flag_perr),
    .flag_ovr     (flag_ovr),
    .flag_wterr   (flag_wterr),
    .rx_data      (rx_data),
    .io_drive_low (io_drive_low),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata)
);

// File: tb/sc_rx_ctrl_tb_top.sv
module sc_rx_ctrl_tb_top;
    localparam int OVS = 4;
    localparam int NACK_ETUS = 1;
    localparam int WT_W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       card_line = 1'b1;
    logic       io_in, io_drive_low;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_rx, irq_err;

    int total = 0;
    int bad = 0;
    int nack_ticks = 0;
    logic [7:0] last_data = 8'h00;
    logic [7:0] rv;

    always #2 clk = ~clk;
    assign io_in = card_line & ~io_drive_low;

    sc_rx_ctrl #(.OVS(OVS), .NACK_ETUS(NACK_ETUS), .WT_W(WT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_tick(tick), .io_in(io_in),
        .io_drive_low(io_drive_low), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    // vector: {t1, bad parity, data}
    localparam logic [9:0] VEC [8] = '{
        {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b0, 8'h00}, {1'b0, 1'b0, 8'hFF},
        {1'b0, 1'b1, 8'h3C}, {1'b1, 1'b0, 8'h81}, {1'b1, 1'b1, 8'h5A},
        {1'b1, 1'b1, 8'h01}, {1'b0, 1'b1, 8'h7E}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk);
        tick = 1'b1;
        if (io_drive_low) nack_ticks++;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) pulse();
    endtask

    task automatic send(input logic [7:0] dat, input logic badp);
        card_line = 1'b0;
        ticks(OVS);
        for (int i = 0; i < 8; i++) begin
            card_line = dat[i];
            ticks(OVS);
        end
        card_line = (^dat) ^ badp;
        ticks(OVS);
        card_line = 1'b1;
        ticks(3 * OVS);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), rv);
            chk("R1 reset reg", int'(rv), 0);
        end
        chk("R1 irq_rx", int'(irq_rx), 0);
        chk("R1 irq_err", int'(irq_err), 0);
        chk("R1 drive", int'(io_drive_low), 0);

        // table walk: R2 R4 R5 R6 R10 R11
        for (int k = 0; k < 8; k++) begin
            logic t1, bp, expf;
            logic [7:0] dv;
            {t1, bp, dv} = VEC[k];
            expf = !(bp && !t1);
            wr(2'd0, {5'b0, 1'b1, t1, 1'b1});
            nack_ticks = 0;
            send(dv, bp);
            rd(2'd1, rv);
            chk("R2 R4 R5 full", int'(rv[0]), int'(expf));
            chk("R4 R5 perr", int'(rv[1]), int'(bp));
            chk("R10 irq_rx", int'(irq_rx), int'(expf));
            chk("R11 irq_err", int'(irq_err), int'(bp));
            chk("R6 nack ticks", nack_ticks, (bp && !t1) ? OVS * NACK_ETUS : 0);
            if (expf) last_data = dv;
            rd(2'd2, rv);
            chk("R2 R4 data", int'(rv), int'(last_data));
            rd(2'd1, rv);
            chk("R3 full cleared", int'(rv[0]), 0);
            wr(2'd1, 8'h00);
        end

        // R7 overrun
        wr(2'd0, 8'h05);
        send(8'h11, 1'b0);
        send(8'h22, 1'b0);
        rd(2'd1, rv);
        chk("R7 full+ovr", int'(rv[2:0]), 3'b101);
        chk("R11 irq_err ovr", int'(irq_err), 1);
        rd(2'd2, rv);
        chk("R7 old data kept", int'(rv), 8'h11);

        // R8 write-one ignored, write-zero clears
        wr(2'd1, 8'hFF);
        rd(2'd1, rv);
        chk("R8 ovr kept on write 1", int'(rv[2]), 1);
        wr(2'd1, 8'hFB);
        rd(2'd1, rv);
        chk("R8 ovr cleared on write 0", int'(rv[2]), 0);

        // R10 error-only masks receive irq; R11 needs enable
        wr(2'd0, 8'h0D);
        send(8'h42, 1'b0);
        chk("R10 eonly masks irq_rx", int'(irq_rx), 0);
        wr(2'd0, 8'h05);
        chk("R10 irq_rx unmasked", int'(irq_rx), 1);
        wr(2'd0, 8'h01);
        chk("R10 irq_rx no rie", int'(irq_rx), 0);
        rd(2'd2, rv);
        chk("R2 data 42", int'(rv), 8'h42);

        // R9 wait time in idle
        wr(2'd3, 8'd3);
        ticks(3 * OVS - 1);
        rd(2'd1, rv);
        chk("R9 no wterr early", int'(rv[3]), 0);
        ticks(1);
        rd(2'd1, rv);
        chk("R9 wterr set", int'(rv[3]), 1);
        wr(2'd3, 8'd0);
        wr(2'd1, 8'h00);
        ticks(10 * OVS);
        rd(2'd1, rv);
        chk("R9 disabled", int'(rv[3]), 0);

        // R9 restart by start bit
        wr(2'd3, 8'd20);
        send(8'h33, 1'b0);
        ticks(28);
        rd(2'd1, rv);
        chk("R9 restart no wterr", int'(rv[3]), 0);
        ticks(1);
        rd(2'd1, rv);
        chk("R9 wterr after restart", int'(rv[3]), 1);
        wr(2'd3, 8'd0);
        wr(2'd1, 8'h00);
        rd(2'd2, rv);

        // R12 disabled receiver ignores line
        wr(2'd0, 8'h04);
        nack_ticks = 0;
        send(8'h99, 1'b1);
        rd(2'd1, rv);
        chk("R12 no flags when disabled", int'(rv[3:0]), 0);
        chk("R12 no nack when disabled", nack_ticks, 0);
        rd(2'd2, rv);
        chk("R12 data untouched", int'(rv), 8'h33);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule